// File: doc/BRIEF.md
# Parallel Host Port for a Character Display Controller

This block sits between a microcontroller's parallel bus and the core of a character display controller. The host drives a register-select line, a read/write line, an enable strobe and a data bus. The block samples the strobe with the system clock and acts on its falling edge. It sends writes to either the instruction path or the data path. On reads it returns either a status word or a data byte supplied by the core. The bidirectional bus is modelled as a separate input, output and output-enable.

Two bus widths are supported. In the wide mode each strobe cycle moves a full byte. In the narrow mode only the upper four data lines carry information, and each byte takes two strobe cycles with the high nibble first. A completed write raises a one-cycle strobe toward the core and sets a busy flag. The busy flag stays set until the core reports completion. The host can poll the flag through the status read.

Top module: `lcd_host_port`

## Requirements
- R1: A completed write with `sel_data`=0 pulses `instr_wr` high for exactly one clock and presents the written byte on `wr_byte`; `data_wr` stays low.
- R2: A completed write with `sel_data`=1 pulses `data_wr` high for exactly one clock and presents the written byte on `wr_byte`; `instr_wr` stays low.
- R3: A read with `sel_data`=0 returns the status word: bit 7 is the busy flag and bits 6..0 are `addr_cnt`.
- R4: A read with `sel_data`=1 returns `rd_byte`. When the read completes on the falling strobe, `data_rd` pulses for one clock.
- R5: `bus_oe` is high only while the synchronised enable is high and `rd_nwr`=1 (1 = read, 0 = write). It is low throughout write cycles.
- R6: Bus values, `sel_data` and `rd_nwr` are taken at the falling edge of `en`. A different bus value held earlier in the same high phase has no effect on `wr_byte`.
- R7: With `wide_mode`=0 a byte is written as two enable cycles on `bus_in[7:4]`, high nibble first. `bus_in[3:0]` is ignored. Only the second cycle produces the write pulse.
- R8: With `wide_mode`=0 a read places the high nibble of the word on `bus_out[7:4]` in the first cycle and the low nibble in the second, with `bus_out[3:0]`=0. `data_rd` pulses only after the second cycle.
- R9: A completed write sets the busy flag in the same clock as its write pulse. `core_done` clears the flag. If a write completes in the same clock as `core_done`, the flag ends set.
- R10: While `wide_mode`=1 the nibble toggle is held at the first half. A half-finished narrow transfer is dropped, and the next narrow transfer starts with the high nibble.
- R11: After reset no pulse is active, `bus_oe`=0 and the busy flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Host enable strobe (asynchronous) |
| sel_data | input | 1 | 0 = instruction/status, 1 = data |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wide_mode | input | 1 | 1 = full-byte bus, 0 = upper-nibble bus |
| bus_in | input | DATA_W | Host data bus, input side |
| bus_out | output | DATA_W | Host data bus, output side |
| bus_oe | output | 1 | Output enable for the host data bus |
| addr_cnt | input | DATA_W-1 | Address counter from the core |
| rd_byte | input | DATA_W | Data byte from the core for data reads |
| core_done | input | 1 | Core finished the pending operation |
| instr_wr | output | 1 | One-cycle instruction write pulse |
| data_wr | output | 1 | One-cycle data write pulse |
| data_rd | output | 1 | One-cycle data read completion pulse |
| wr_byte | output | DATA_W | Byte written by the host |

## Verification
A completing host write and the core's completion signal can fall in the same clock. One sets the busy flag and the other clears it. The bench drops `en` and then raises `core_done` for exactly the clock in which the synchronised falling strobe is seen. A status read that follows must still show bit 7 set. A later lone `core_done` must clear the flag.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    EV_INSTR_WR = 2'd0,
    EV_DATA_WR  = 2'd1,
    EV_DATA_RD  = 2'd2
  } hp_event_e;

  function automatic logic [7:0] status_word(input logic busy, input logic [6:0] addr);
    return {busy, addr};
  endfunction
endpackage

// File: rtl/hp_edge_sync.sv
module hp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign fall  = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/hp_xfer_ctrl.sv
module hp_xfer_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              wide_mode,
  input  logic              rd_nwr,
  input  logic              sel_data,
  input  logic [DATA_W-1:0] bus_in,
  output logic              nib_lo,
  output logic              wr_commit,
  output logic              instr_wr,
  output logic              data_wr,
  output logic              data_rd,
  output logic [DATA_W-1:0] wr_byte
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] hi_q;
  logic             last_half;

  assign last_half = wide_mode | nib_lo;
  assign wr_commit = fall & ~rd_nwr & last_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_lo   <= 1'b0;
      hi_q     <= '0;
      instr_wr <= 1'b0;
      data_wr  <= 1'b0;
      data_rd  <= 1'b0;
      wr_byte  <= '0;
    end else begin
      instr_wr <= 1'b0;
      data_wr  <= 1'b0;
      data_rd  <= 1'b0;
      if (wide_mode) nib_lo <= 1'b0;
      if (fall) begin
        if (!wide_mode) nib_lo <= ~nib_lo;
        if (!rd_nwr) begin
          if (wide_mode)    wr_byte <= bus_in;
          else if (!nib_lo) hi_q    <= bus_in[DATA_W-1 -: NIB_W];
          else              wr_byte <= {hi_q, bus_in[DATA_W-1 -: NIB_W]};
        end
        if (last_half) begin
          if (!rd_nwr) begin
            instr_wr <= ~sel_data;
            data_wr  <= sel_data;
          end else begin
            data_rd  <= sel_data;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hp_busy_flag.sv
module hp_busy_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)        busy <= 1'b0;
    else if (set_i) busy <= 1'b1;
    else if (clr_i) busy <= 1'b0;
  end
endmodule

// File: rtl/hp_read_path.sv
module hp_read_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_hi,
  input  logic              rd_nwr,
  input  logic              sel_data,
  input  logic              wide_mode,
  input  logic              nib_lo,
  input  logic              busy,
  input  logic [DATA_W-2:0] addr_cnt,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] shaped;
  logic              driving;

  assign driving = e_hi & rd_nwr;

  always_comb begin
    word = sel_data ? rd_byte : {busy, addr_cnt};
    if (wide_mode)   shaped = word;
    else if (nib_lo) shaped = {word[NIB_W-1:0], {NIB_W{1'b0}}};
    else             shaped = {word[DATA_W-1 -: NIB_W], {NIB_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      bus_oe  <= driving;
      bus_out <= driving ? shaped : '0;
    end
  end
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel_data,
  input  logic              rd_nwr,
  input  logic              wide_mode,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-2:0] addr_cnt,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              core_done,
  output logic              instr_wr,
  output logic              data_wr,
  output logic              data_rd,
  output logic [DATA_W-1:0] wr_byte
);
  logic e_hi;
  logic e_fall;
  logic nib_lo;
  logic wr_commit;
  logic busy_q;

  hp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(en), .level(e_hi), .fall(e_fall)
  );

  hp_xfer_ctrl #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst), .fall(e_fall), .wide_mode(wide_mode),
    .rd_nwr(rd_nwr), .sel_data(sel_data), .bus_in(bus_in),
    .nib_lo(nib_lo), .wr_commit(wr_commit), .instr_wr(instr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte)
  );

  hp_busy_flag u_busy (
    .clk(clk), .rst(rst), .set_i(wr_commit), .clr_i(core_done), .busy(busy_q)
  );

  hp_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .e_hi(e_hi), .rd_nwr(rd_nwr), .sel_data(sel_data),
    .wide_mode(wide_mode), .nib_lo(nib_lo), .busy(busy_q),
    .addr_cnt(addr_cnt), .rd_byte(rd_byte), .bus_out(bus_out), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/lcd_host_port_chk.sv
module lcd_host_port_chk (
  input logic clk,
  input logic rst,
  input logic rd_nwr,
  input logic core_done,
  input logic instr_wr,
  input logic data_wr,
  input logic data_rd,
  input logic bus_oe,
  input logic e_hi,
  input logic busy,
  input logic wr_commit
);
  a_r1_instr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    instr_wr |=> !instr_wr);
  a_r2_data_one_cycle: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !data_wr);
  a_r1_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({instr_wr, data_wr, data_rd}));
  a_r4_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !data_rd);
  a_r5_oe_only_read: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(rd_nwr));
  a_r5_oe_only_enable: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(e_hi));
  a_r9_busy_with_pulse: assert property (@(posedge clk) disable iff (rst)
    (instr_wr || data_wr) |-> busy);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> busy);
  a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
    (core_done && !wr_commit) |=> !busy);
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!bus_oe && !instr_wr && !data_wr && !data_rd && !busy));
endmodule

bind lcd_host_port lcd_host_port_chk u_chk (
  .clk(clk), .rst(rst), .rd_nwr(rd_nwr), .core_done(core_done),
  .instr_wr(instr_wr), .data_wr(data_wr), .data_rd(data_rd),
  .bus_oe(bus_oe), .e_hi(e_hi), .busy(busy_q), .wr_commit(wr_commit)
);

// File: tb/lcd_host_port_tb.sv
module lcd_host_port_tb;
  import hp_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, sel_data = 1'b0, rd_nwr = 1'b0, wide_mode = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [6:0] addr_cnt = 7'h15;
  logic [7:0] rd_byte = 8'h00;
  logic       core_done = 1'b0;
  logic       instr_wr, data_wr, data_rd;
  logic [7:0] wr_byte;

  int checks = 0;
  int errors = 0;
  logic [9:0] sb_q[$];
  logic exp_lo = 1'b0;

  always #2.5 clk = ~clk;

  lcd_host_port u_dut (
    .clk(clk), .rst(rst), .en(en), .sel_data(sel_data), .rd_nwr(rd_nwr),
    .wide_mode(wide_mode), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .addr_cnt(addr_cnt), .rd_byte(rd_byte), .core_done(core_done),
    .instr_wr(instr_wr), .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1/R2/R4 scoreboard: actual %0d leftover expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One enable cycle. early: bus value in the high phase; late: value at the fall.
  task automatic bus_cycle(input logic rs, input logic rw, input logic [7:0] early,
                           input logic [7:0] late, input logic [7:0] exp_out,
                           input logic collide, input string req);
    logic last;
    last = wide_mode | exp_lo;
    @(negedge clk);
    sel_data = rs; rd_nwr = rw; bus_in = early; en = 1'b1;
    repeat (5) @(negedge clk);
    check({req, " oe"}, {31'd0, bus_oe}, {31'd0, rw});
    if (rw) check({req, " out"}, {24'd0, bus_out}, {24'd0, exp_out});
    bus_in = late;
    @(negedge clk);
    if (last) begin
      if (!rw) sb_q.push_back({rs ? EV_DATA_WR : EV_INSTR_WR, 8'h00});
      else if (rs) sb_q.push_back({EV_DATA_RD, 8'h00});
    end
    en = 1'b0;
    repeat (2) @(negedge clk);
    core_done = collide;
    @(negedge clk);
    core_done = 1'b0;
    repeat (4) @(negedge clk);
    if (!wide_mode) exp_lo = ~exp_lo;
  endtask

  task automatic done_pulse();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  logic [7:0] exp_bytes[$];

  // Monitor: pops scoreboard entries when pulses appear.
  always @(negedge clk) begin
    if (!rst && (instr_wr || data_wr || data_rd)) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1/R2/R4 unexpected pulse: actual %b expected none", {instr_wr, data_wr, data_rd});
      end else begin
        logic [9:0] item;
        logic [1:0] kind;
        item = sb_q.pop_front();
        kind = instr_wr ? 2'd0 : (data_wr ? 2'd1 : 2'd2);
        check("R1/R2/R4 pulse kind", {30'd0, kind}, {30'd0, item[9:8]});
        if (kind != 2'd2) begin
          check("R1/R2/R7 wr_byte", {24'd0, wr_byte}, {24'd0, exp_bytes[0]});
          void'(exp_bytes.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: quiet after reset
    check("R11 oe", {31'd0, bus_oe}, 32'd0);
    check("R11 pulses", {29'd0, instr_wr, data_wr, data_rd}, 32'd0);
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h15, 1'b0, "R11 status busy clear");

    // R1 + R6: instruction write, bus changes before the fall
    exp_bytes.push_back(8'h38);
    bus_cycle(1'b0, 1'b0, 8'hFF, 8'h38, 8'h00, 1'b0, "R1 R5 R6 instr write");
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h95, 1'b0, "R3 R9 status busy");
    done_pulse();
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h15, 1'b0, "R3 R9 status cleared");

    // R2: data write
    exp_bytes.push_back(8'h5A);
    bus_cycle(1'b1, 1'b0, 8'h00, 8'h5A, 8'h00, 1'b0, "R2 data write");
    done_pulse();

    // R4: data read
    rd_byte = 8'hC3;
    bus_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'hC3, 1'b0, "R4 data read");

    // R7: narrow write, low lines hold junk
    wide_mode = 1'b0;
    exp_bytes.push_back(8'h2C);
    bus_cycle(1'b0, 1'b0, 8'h2F, 8'h2F, 8'h00, 1'b0, "R7 instr high nibble");
    bus_cycle(1'b0, 1'b0, 8'hCA, 8'hCA, 8'h00, 1'b0, "R7 instr low nibble");
    done_pulse();

    // R8: narrow data read and narrow status read
    rd_byte = 8'hA5;
    bus_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'hA0, 1'b0, "R8 read high nibble");
    bus_cycle(1'b1, 1'b1, 8'h00, 8'h00, 8'h50, 1'b0, "R8 read low nibble");
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h10, 1'b0, "R3 R8 status high nibble");
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h50, 1'b0, "R3 R8 status low nibble");

    // R10: half transfer dropped by switching to wide mode
    bus_cycle(1'b1, 1'b0, 8'h70, 8'h70, 8'h00, 1'b0, "R10 orphan nibble");
    @(negedge clk); wide_mode = 1'b1; exp_lo = 1'b0;
    exp_bytes.push_back(8'h66);
    bus_cycle(1'b1, 1'b0, 8'h66, 8'h66, 8'h00, 1'b0, "R10 wide write");
    done_pulse();
    @(negedge clk); wide_mode = 1'b0;
    exp_bytes.push_back(8'h91);
    bus_cycle(1'b1, 1'b0, 8'h93, 8'h93, 8'h00, 1'b0, "R10 narrow high");
    bus_cycle(1'b1, 1'b0, 8'h1E, 8'h1E, 8'h00, 1'b0, "R10 narrow low");
    done_pulse();
    @(negedge clk); wide_mode = 1'b1; exp_lo = 1'b0;

    // R9: write completion and core_done in the same clock
    exp_bytes.push_back(8'h01);
    bus_cycle(1'b0, 1'b0, 8'h01, 8'h01, 8'h00, 1'b1, "R9 collide write");
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h95, 1'b0, "R9 set wins over done");
    done_pulse();
    bus_cycle(1'b0, 1'b1, 8'h00, 8'h00, 8'h15, 1'b0, "R9 later done clears");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule